// File: doc/BRIEF.md
# Sparse-Coded Integer ALU

This block is a W-bit integer arithmetic and logic unit. It takes two operands and a 6-bit function select, and it returns one result word and four condition flags: overflow, zero, carry and sign. The function codes are spread over three ranges: shifts sit in the lowest range, multiply and divide in the middle range, and add, subtract, bitwise logic and the signed compare in the top range. All codes outside the defined set are treated as unused.

The whole operation is evaluated in one cycle, with no iteration. The parameter `OUT_REG` chooses whether the result and flags pass through an output register that has an asynchronous active-low reset, or leave the block straight from the logic. Another parameter chooses how the shifter is built: either a log-depth barrel or a plain shift operator.

Top module: `ialu6`

## Requirements
- R1: Code 0x00 shifts A left, code 0x02 shifts A right with zero fill, and code 0x03 shifts A right with sign fill. The shift amount is B[log2(W)-1:0] and all higher B bits are ignored.
- R2: Codes 0x18 (signed) and 0x19 (unsigned) return the low W bits of A times B.
- R3: Code 0x1B returns the unsigned quotient A/B. Code 0x1A returns the signed quotient, truncated toward zero. The most negative value divided by -1 returns the most negative value.
- R4: For codes 0x1A and 0x1B, a zero divisor returns all ones, with overflow and carry both 0.
- R5: Code 0x20 returns A+B. Carry is the unsigned carry-out and overflow is signed overflow. For example, 0x7fffffff+0x00000001 gives 0x80000000 with overflow=1, zero=0, carry=0 and sign=1.
- R6: Code 0x22 returns A-B. Carry is 1 exactly when A<B unsigned (a borrow), and overflow is signed overflow.
- R7: Codes 0x24, 0x25, 0x26 and 0x27 return A AND B, A OR B, A XOR B and A NOR B.
- R8: Code 0x2A returns 1 when A<B as signed numbers, and 0 otherwise.
- R9: For every defined code, zero is 1 exactly when the result is 0, and sign equals the result MSB. Overflow and carry are 0 for every code except 0x20 and 0x22.
- R10: Any code not listed in R1 to R8 returns result 0, with all four flags 0.
- R11: With `OUT_REG`=1, the result and flags appear one clock edge after the inputs are applied. While reset is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand, divisor, or shift amount |
| fsel | input | 6 | Function select code |
| result | output | W | Operation result |
| flag_v | output | 1 | Signed overflow |
| flag_z | output | 1 | Result is zero |
| flag_c | output | 1 | Carry-out (add) or borrow (subtract) |
| flag_n | output | 1 | Result sign bit |

## Verification
The block holds no state apart from the output register. Any internal fault therefore shows up at the ports in the very cycle the faulty code is used, or one edge later when the output register is present. A wrong decode of a sparse code shows up as a zero result with quiet flags, or as a foreign result on a code that should be unused. A wrong carry sense in the shared adder inverts the borrow on subtract, or breaks the signed compare. The bench sweeps all 64 codes and places operand corner values at each edge of overflow, zero and sign.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
   localparam int FSEL_W = 6;

   localparam logic [FSEL_W-1:0] FS_SLL  = 6'h00;
   localparam logic [FSEL_W-1:0] FS_SRL  = 6'h02;
   localparam logic [FSEL_W-1:0] FS_SRA  = 6'h03;
   localparam logic [FSEL_W-1:0] FS_MULS = 6'h18;
   localparam logic [FSEL_W-1:0] FS_MULU = 6'h19;
   localparam logic [FSEL_W-1:0] FS_DIVS = 6'h1A;
   localparam logic [FSEL_W-1:0] FS_DIVU = 6'h1B;
   localparam logic [FSEL_W-1:0] FS_ADD  = 6'h20;
   localparam logic [FSEL_W-1:0] FS_SUB  = 6'h22;
   localparam logic [FSEL_W-1:0] FS_AND  = 6'h24;
   localparam logic [FSEL_W-1:0] FS_OR   = 6'h25;
   localparam logic [FSEL_W-1:0] FS_XOR  = 6'h26;
   localparam logic [FSEL_W-1:0] FS_NOR  = 6'h27;
   localparam logic [FSEL_W-1:0] FS_SLT  = 6'h2A;

   typedef enum logic [1:0] {
      GRP_NONE   = 2'd0,
      GRP_SHIFT  = 2'd1,
      GRP_MULDIV = 2'd2,
      GRP_ARITH  = 2'd3
   } grp_e;

   typedef struct packed {
      logic v;
      logic z;
      logic c;
      logic n;
   } flags_t;

   function automatic grp_e classify(input logic [FSEL_W-1:0] f);
      grp_e g;
      case (f)
         FS_SLL, FS_SRL, FS_SRA:                    g = GRP_SHIFT;
         FS_MULS, FS_MULU, FS_DIVS, FS_DIVU:        g = GRP_MULDIV;
         FS_ADD, FS_SUB, FS_AND, FS_OR, FS_XOR,
         FS_NOR, FS_SLT:                            g = GRP_ARITH;
         default:                                   g = GRP_NONE;
      endcase
      return g;
   endfunction
endpackage

// File: rtl/ialu_shift.sv
module ialu_shift import ialu_pkg::*; #(
   parameter int W          = 32,
   parameter int SHIFT_IMPL = 1
) (
   input  logic [W-1:0]      op_a,
   input  logic [W-1:0]      op_b,
   input  logic [FSEL_W-1:0] fsel,
   output logic [W-1:0]      res
);
   localparam int SHW = $clog2(W);

   logic [SHW-1:0] amt;
   logic           to_left;
   logic           fill;

   assign amt     = op_b[SHW-1:0];
   assign to_left = (fsel == FS_SLL);
   assign fill    = (fsel == FS_SRA) ? op_a[W-1] : 1'b0;

   generate
      if (SHIFT_IMPL == 1) begin : g_barrel
         logic [SHW:0][W-1:0] stg;
         assign stg[0] = op_a;
         for (genvar i = 0; i < SHW; i++) begin : g_stage
            localparam int K = 1 << i;
            logic [W-1:0] moved;
            assign moved = to_left ? {stg[i][W-K-1:0], {K{1'b0}}}
                                   : {{K{fill}}, stg[i][W-1:K]};
            assign stg[i+1] = amt[i] ? moved : stg[i];
         end
         assign res = stg[SHW];
      end else begin : g_operator
         always_comb begin
            if (to_left)
               res = op_a << amt;
            else if (fill)
               res = ~((~op_a) >> amt);
            else
               res = op_a >> amt;
         end
      end
   endgenerate

   always_comb begin
      if (fsel == FS_SRA)
         p_sra_sign_r1: assert (res[W-1] == op_a[W-1]);
      if (fsel == FS_SRL && amt != '0)
         p_srl_msb_r1: assert (res[W-1] == 1'b0);
   end
endmodule

// File: rtl/ialu_muldiv.sv
module ialu_muldiv import ialu_pkg::*; #(
   parameter int W = 32
) (
   input  logic [W-1:0]      op_a,
   input  logic [W-1:0]      op_b,
   input  logic [FSEL_W-1:0] fsel,
   output logic [W-1:0]      res
);
   localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] prod;
   logic [W-1:0] q_u;
   logic [W-1:0] q_s;
   logic         b_zero;
   logic         s_wrap;

   assign prod   = op_a * op_b;
   assign b_zero = (op_b == '0);
   assign s_wrap = (op_a == MIN_NEG) && (op_b == '1);
   assign q_u    = b_zero ? '1 : op_a / op_b;
   assign q_s    = (b_zero || s_wrap) ? '0 : W'($signed(op_a) / $signed(op_b));

   always_comb begin
      case (fsel)
         FS_MULS, FS_MULU: res = prod;
         FS_DIVS:          res = b_zero ? '1 : (s_wrap ? MIN_NEG : q_s);
         FS_DIVU:          res = q_u;
         default:          res = '0;
      endcase
   end

   always_comb begin
      if ((fsel == FS_DIVS || fsel == FS_DIVU) && b_zero)
         p_div0_ones_r4: assert (res == '1);
      if (fsel == FS_DIVU && !b_zero)
         p_divu_bound_r3: assert (res <= op_a);
   end
endmodule

// File: rtl/ialu_arith.sv
module ialu_arith import ialu_pkg::*; #(
   parameter int W = 32
) (
   input  logic [W-1:0]      op_a,
   input  logic [W-1:0]      op_b,
   input  logic [FSEL_W-1:0] fsel,
   output logic [W-1:0]      res,
   output logic              ovf,
   output logic              cry
);
   logic         do_sub;
   logic [W-1:0] b_eff;
   logic [W-1:0] sum;
   logic         cout;
   logic         s_ovf;

   assign do_sub = (fsel == FS_SUB) || (fsel == FS_SLT);
   assign b_eff  = do_sub ? ~op_b : op_b;
   assign {cout, sum} = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
   assign s_ovf  = (op_a[W-1] == b_eff[W-1]) && (sum[W-1] != op_a[W-1]);

   always_comb begin
      res = '0;
      ovf = 1'b0;
      cry = 1'b0;
      case (fsel)
         FS_ADD: begin res = sum; ovf = s_ovf; cry = cout;  end
         FS_SUB: begin res = sum; ovf = s_ovf; cry = ~cout; end
         FS_AND: res = op_a & op_b;
         FS_OR:  res = op_a | op_b;
         FS_XOR: res = op_a ^ op_b;
         FS_NOR: res = ~(op_a | op_b);
         FS_SLT: res = {{(W-1){1'b0}}, sum[W-1] ^ s_ovf};
         default: res = '0;
      endcase
   end

   always_comb begin
      if (fsel == FS_ADD)
         p_add_wide_r5: assert ({cry, res} == ({1'b0, op_a} + {1'b0, op_b}));
      if (fsel == FS_SUB)
         p_sub_borrow_r6: assert (cry == (op_a < op_b));
      if (fsel == FS_SLT)
         p_slt_signed_r8: assert (res[0] == ($signed(op_a) < $signed(op_b)));
   end
endmodule

// File: rtl/ialu6.sv
module ialu6 import ialu_pkg::*; #(
   parameter int W          = 32,
   parameter bit OUT_REG    = 1'b1,
   parameter int SHIFT_IMPL = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      op_a,
   input  logic [W-1:0]      op_b,
   input  logic [FSEL_W-1:0] fsel,
   output logic [W-1:0]      result,
   output logic              flag_v,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_n
);
   generate
      if (W < 8 || (W & (W - 1)) != 0) begin : g_bad_width
         $error("ialu6: W must be a power of two of at least 8");
      end
      if (SHIFT_IMPL != 0 && SHIFT_IMPL != 1) begin : g_bad_shift
         $error("ialu6: SHIFT_IMPL must be 0 or 1");
      end
   endgenerate

   grp_e         grp;
   logic [W-1:0] sh_res;
   logic [W-1:0] md_res;
   logic [W-1:0] ar_res;
   logic         ar_ovf;
   logic         ar_cry;
   logic [W-1:0] nxt_res;
   flags_t       nxt_fl;
   flags_t       out_fl;

   assign grp = classify(fsel);

   ialu_shift #(.W(W), .SHIFT_IMPL(SHIFT_IMPL)) u_shift (
      .op_a(op_a), .op_b(op_b), .fsel(fsel), .res(sh_res)
   );

   ialu_muldiv #(.W(W)) u_muldiv (
      .op_a(op_a), .op_b(op_b), .fsel(fsel), .res(md_res)
   );

   ialu_arith #(.W(W)) u_arith (
      .op_a(op_a), .op_b(op_b), .fsel(fsel),
      .res(ar_res), .ovf(ar_ovf), .cry(ar_cry)
   );

   always_comb begin
      nxt_res  = '0;
      nxt_fl   = '0;
      case (grp)
         GRP_SHIFT:  nxt_res = sh_res;
         GRP_MULDIV: nxt_res = md_res;
         GRP_ARITH: begin
            nxt_res  = ar_res;
            nxt_fl.v = ar_ovf;
            nxt_fl.c = ar_cry;
         end
         default:    nxt_res = '0;
      endcase
      if (grp != GRP_NONE) begin
         nxt_fl.z = (nxt_res == '0);
         nxt_fl.n = nxt_res[W-1];
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               result <= '0;
               out_fl <= '0;
            end else begin
               result <= nxt_res;
               out_fl <= nxt_fl;
            end
         end

         p_undef_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (grp == GRP_NONE) |=> (result == '0 && !flag_v && !flag_z && !flag_c && !flag_n));
         p_nocarry_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (fsel != FS_ADD && fsel != FS_SUB) |=> (!flag_c && !flag_v));
         p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
            flag_z |-> (result == '0));
         p_add_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (fsel == FS_ADD) |=> (result == $past(op_a) + $past(op_b)));
      end else begin : g_comb
         assign result = nxt_res;
         assign out_fl = nxt_fl;
      end
   endgenerate

   assign flag_v = out_fl.v;
   assign flag_z = out_fl.z;
   assign flag_c = out_fl.c;
   assign flag_n = out_fl.n;
endmodule

// File: tb/ialu6_bench.sv
`timescale 1ns/1ps
module ialu6_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [5:0]  fsel = '0;
   logic [31:0] result;
   logic        flag_v, flag_z, flag_c, flag_n;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   ialu6 u_ialu6 (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .fsel(fsel),
      .result(result), .flag_v(flag_v), .flag_z(flag_z),
      .flag_c(flag_c), .flag_n(flag_n)
   );

   // Independent model: returns {result, v, z, c, n}
   function automatic logic [35:0] model(input logic [5:0] f, input logic [31:0] a,
                                         input logic [31:0] b);
      logic [31:0] r;
      logic v, c, def;
      logic [32:0] wide;
      longint sa, sb;
      r = 0; v = 0; c = 0; def = 1;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      case (f)
         6'h00: r = a << b[4:0];
         6'h02: r = a >> b[4:0];
         6'h03: r = 32'($signed(a) >>> b[4:0]);
         6'h18: r = 32'(sa * sb);
         6'h19: r = 32'(longint'(a) * longint'(b));
         6'h1A: r = (b == 0) ? 32'hffffffff : 32'(sa / sb);
         6'h1B: r = (b == 0) ? 32'hffffffff : a / b;
         6'h20: begin
            wide = 33'(a) + 33'(b); r = wide[31:0]; c = wide[32];
            v = (sa + sb > 64'sd2147483647) || (sa + sb < -64'sd2147483648);
         end
         6'h22: begin
            r = a - b; c = (a < b);
            v = (sa - sb > 64'sd2147483647) || (sa - sb < -64'sd2147483648);
         end
         6'h24: r = a & b;
         6'h25: r = a | b;
         6'h26: r = a ^ b;
         6'h27: r = ~(a | b);
         6'h2A: r = (sa < sb) ? 32'd1 : 32'd0;
         default: def = 0;
      endcase
      return {r, v, def && (r == 0), c, def && r[31]};
   endfunction

   task automatic compare(input string tag, input logic [35:0] exp);
      logic [35:0] got;
      got = {result, flag_v, flag_z, flag_c, flag_n};
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s fsel=%h a=%h b=%h got=%h/vzcn=%b expected=%h/vzcn=%b",
                  tag, fsel, op_a, op_b, got[35:4], got[3:0], exp[35:4], exp[3:0]);
      end
   endtask

   task automatic run(input string tag, input logic [5:0] f, input logic [31:0] a,
                      input logic [31:0] b);
      @(negedge clk);
      fsel = f; op_a = a; op_b = b;
      @(negedge clk);
      compare(tag, model(f, a, b));
   endtask

   task automatic t_reset();
      @(negedge clk);
      fsel = 6'h20; op_a = 32'h1234; op_b = 32'h1;
      @(negedge clk);
      compare("R11 reset", 36'h0);
      rst_n = 1'b1;
   endtask

   task automatic t_latency();
      logic [35:0] prev;
      run("R11 setup", 6'h20, 32'd5, 32'd6);
      prev = model(6'h20, 32'd5, 32'd6);
      @(negedge clk);
      fsel = 6'h24; op_a = 32'hf0f0; op_b = 32'h0ff0;
      #1 compare("R11 hold before edge", prev);
      @(negedge clk);
      compare("R11 after edge", model(6'h24, 32'hf0f0, 32'h0ff0));
   endtask

   task automatic t_shift();
      run("R1 sll", 6'h00, 32'h0000_00f1, 32'd4);
      run("R1 sll high b ignored", 6'h00, 32'h1, 32'hffff_ffe3);
      run("R1 srl", 6'h02, 32'h8000_0000, 32'd31);
      run("R1 sra", 6'h03, 32'h8000_0010, 32'd4);
      run("R1 sra zero amt", 6'h03, 32'h9000_0000, 32'h20);
   endtask

   task automatic t_muldiv();
      run("R2 muls", 6'h18, 32'hffff_fffd, 32'd7);
      run("R2 mulu", 6'h19, 32'h0001_0001, 32'h0001_0001);
      run("R3 divs", 6'h1A, 32'hffff_fff9, 32'd2);
      run("R3 divs wrap", 6'h1A, 32'h8000_0000, 32'hffff_ffff);
      run("R3 divu", 6'h1B, 32'hffff_fff9, 32'd2);
      run("R4 divs by zero", 6'h1A, 32'd77, 32'd0);
      run("R4 divu by zero", 6'h1B, 32'd0, 32'd0);
   endtask

   task automatic t_addsub();
      run("R5 add overflow", 6'h20, 32'h7fff_ffff, 32'h0000_0001);
      run("R5 add carry zero", 6'h20, 32'hffff_ffff, 32'h0000_0001);
      run("R5 add neg overflow", 6'h20, 32'h8000_0000, 32'h8000_0000);
      run("R6 sub borrow", 6'h22, 32'd3, 32'd5);
      run("R6 sub equal", 6'h22, 32'd9, 32'd9);
      run("R6 sub overflow", 6'h22, 32'h8000_0000, 32'd1);
   endtask

   task automatic t_logic();
      run("R7 and", 6'h24, 32'hff00_ff00, 32'h0ff0_0ff0);
      run("R7 or", 6'h25, 32'hff00_0000, 32'h0000_00ff);
      run("R7 xor", 6'h26, 32'haaaa_aaaa, 32'haaaa_aaaa);
      run("R7 nor", 6'h27, 32'h0, 32'h0);
      run("R9 nor sign", 6'h27, 32'h0000_ffff, 32'h0);
   endtask

   task automatic t_slt();
      run("R8 slt neg", 6'h2A, 32'hffff_ffff, 32'd1);
      run("R8 slt pos", 6'h2A, 32'd1, 32'hffff_ffff);
      run("R8 slt extremes", 6'h2A, 32'h8000_0000, 32'h7fff_ffff);
      run("R8 slt equal", 6'h2A, 32'd4, 32'd4);
   endtask

   task automatic t_sweep();
      for (int f = 0; f < 64; f++) begin
         run("R9 R10 code sweep", 6'(f), 32'h8765_4321, 32'h0000_0013);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_latency();
      t_shift();
      t_muldiv();
      t_addsub();
      t_logic();
      t_slt();
      t_sweep();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule